// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns single-cycle commands from an I2C master controller into correctly timed SCL and SDA waveforms. A 6-bit rate index picks four cycle counts: the bit period, the delay from an SCL falling edge to an SDA change, the SCL hold after a START, and the SDA delay after SCL rises in a STOP. Both lines are driven open-drain style. An enable output of 1 pulls the line low and 0 releases it.

A controller issues one of four commands (START, STOP, write one bit, read one bit) and waits for the one-cycle completion pulse. After a read, the sampled bit is held on an output until the next read finishes. Byte framing, arbitration and clock stretching belong to the surrounding controller.

Top module: `i2c_bt_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both line enables are 0 (released), the completion pulse is low and the read-bit output is 0.
- R2: The rate index maps to (bit period, SDA delay, START hold, STOP hold) in cycles as follows: 0x14 gives (80,17,34,41), 0x18 gives (80,9,38,41), 0x1E gives (192,33,94,97), 0x36 gives (1536,257,766,769) and 0x3F gives (3840,513,1918,1921). Any index below 0x14 behaves as 0x14. For every index the STOP hold is half the period plus one.
- R3: A write bit accepted at clock edge E0 does the following. The SDA enable takes the inverse of the sampled bit at E0+SDA delay. SCL is released at E0+period/2. SCL is pulled low again at E0+period, and the completion pulse is high on that same edge.
- R4: A read bit has the same SCL timing as a write bit and releases SDA at E0+SDA delay. It samples sda_i at E0+3*period/4, which is the middle of the SCL high phase. The sampled value appears on rd_bit_o and holds there until the next read.
- R5: A START releases SDA at E0 and leaves SCL unchanged until E0+period/2, then releases SCL. It pulls SDA low at E0+period and pulls SCL low at E0+period+START hold, together with the completion pulse. This works both from an idle bus and as a repeated START with SCL low.
- R6: A STOP pulls SDA low at E0+SDA delay and releases SCL at E0+period/2. It releases SDA at E0+period/2+STOP hold, together with the completion pulse.
- R7: The rate index and the write bit are sampled only on the accepting edge. Changing them during a command has no effect on that command.
- R8: Command strobes that arrive while a command is running are ignored. Strobes that arrive together while the block is idle are served in the priority order START, STOP, write, read.
- R9: The completion pulse lasts exactly one cycle. SCL and SDA never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_idx_i | input | 6 | Clock-rate index |
| start_i | input | 1 | START command strobe |
| stop_i | input | 1 | STOP command strobe |
| wr_i | input | 1 | Write-bit command strobe |
| rd_i | input | 1 | Read-bit command strobe |
| wr_bit_i | input | 1 | Bit value for a write |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | One-cycle completion pulse |
| rd_bit_o | output | 1 | Last bit sampled by a read |

## Verification
The bench times every line edge against the accepting edge at five rates, including the shortest and longest periods and an index below the table. An off-by-one in the shared counter or in any phase boundary shows up there as an edge one cycle early or late. It also changes the index and the write bit in mid-command and fires strobes during a busy command. A design that re-reads its inputs would stretch the bit to the slow rate or flip SDA, and one that accepts strobes while busy would emit a second completion pulse. Simultaneous strobes and a repeated START from a low SCL are also exercised: a wrong priority shows up as write timing in place of STOP timing, and a START that skips its setup phase never releases SCL.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  localparam int IDX_W = 6;
  localparam int CNT_W = 12;
  localparam logic [IDX_W-1:0] IDX_MIN = 6'h14;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] sda_dly;
    logic [CNT_W-1:0] sta_hold;
    logic [CNT_W-1:0] sto_hold;
  } rate_t;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_SU, S_STA_HI, S_STA_HD,
    S_BIT_L1, S_BIT_L2, S_BIT_H1, S_BIT_H2,
    S_STO_L1, S_STO_L2, S_STO_HD
  } phase_e;

  // Groups of eight indices share a base row; each upper group doubles it.
  function automatic rate_t rate_lookup(logic [IDX_W-1:0] idx);
    rate_t r;
    logic [IDX_W-1:0] e;
    logic [2:0] grp, col, shf;
    logic [CNT_W-1:0] base, dly;
    e   = (idx < IDX_MIN) ? IDX_MIN : idx;
    grp = e[5:3];
    col = e[2:0];
    shf = grp - 3'd3;
    if (grp == 3'd2) begin
      case (col[1:0])
        2'd0:    begin base = 12'd80;  dly = 12'd17; end
        2'd1:    begin base = 12'd88;  dly = 12'd17; end
        2'd2:    begin base = 12'd104; dly = 12'd21; end
        default: begin base = 12'd128; dly = 12'd21; end
      endcase
      r.sta_hold = (base >> 1) - 12'd6;
    end else begin
      case (col)
        3'd0:    base = 12'd80;
        3'd1:    base = 12'd96;
        3'd2:    base = 12'd112;
        3'd3:    base = 12'd128;
        3'd4:    base = 12'd144;
        3'd5:    base = 12'd160;
        3'd6:    base = 12'd192;
        default: base = 12'd240;
      endcase
      base = base << shf;
      dly  = ((12'd8 * ({9'd0, col >> 1} + 12'd1)) << shf) + 12'd1;
      r.sta_hold = (base >> 1) - 12'd2;
    end
    r.period   = base;
    r.sda_dly  = dly;
    r.sto_hold = (base >> 1) + 12'd1;
    return r;
  endfunction
endpackage

// File: rtl/i2c_bt_rate_lut.sv
module i2c_bt_rate_lut
  import i2c_bt_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output rate_t            rate_o
);
  always_comb rate_o = rate_lookup(idx_i);
endmodule

// File: rtl/i2c_bt_timer.sv
module i2c_bt_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // A phase loaded with len lasts exactly len cycles.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             wr_bit_i,
  input  logic             sda_i,
  input  rate_t            rate_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             rd_bit_o
);
  phase_e state_q, state_d;
  rate_t  rate_q, r;
  logic   is_rd_q, is_rd_d, wbit_q, wbit_d;
  logic   scl_q, scl_d, sda_q, sda_d, done_q, done_d, rbit_q, rbit_d;
  logic   accept;
  logic [CNT_W-1:0] half, quarter;

  assign accept  = (state_q == S_IDLE) && (start_i || stop_i || wr_i || rd_i);
  assign r       = (state_q == S_IDLE) ? rate_i : rate_q;
  assign half    = r.period >> 1;
  assign quarter = r.period >> 2;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    len_o   = '0;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done_d  = 1'b0;
    rbit_d  = rbit_q;
    is_rd_d = is_rd_q;
    wbit_d  = wbit_q;
    unique case (state_q)
      S_IDLE: begin
        load_o = accept;
        if (start_i) begin
          state_d = S_STA_SU; len_o = half; sda_d = 1'b0;
        end else if (stop_i) begin
          state_d = S_STO_L1; len_o = r.sda_dly;
        end else if (wr_i || rd_i) begin
          state_d = S_BIT_L1; len_o = r.sda_dly;
          is_rd_d = !wr_i;
          wbit_d  = wr_bit_i;
        end
      end
      S_STA_SU: if (expire_i) begin
        state_d = S_STA_HI; load_o = 1'b1; len_o = half; scl_d = 1'b0;
      end
      S_STA_HI: if (expire_i) begin
        state_d = S_STA_HD; load_o = 1'b1; len_o = r.sta_hold; sda_d = 1'b1;
      end
      S_STA_HD: if (expire_i) begin
        state_d = S_IDLE; scl_d = 1'b1; done_d = 1'b1;
      end
      S_BIT_L1: if (expire_i) begin
        state_d = S_BIT_L2; load_o = 1'b1; len_o = half - r.sda_dly;
        sda_d = is_rd_q ? 1'b0 : !wbit_q;
      end
      S_BIT_L2: if (expire_i) begin
        state_d = S_BIT_H1; load_o = 1'b1; len_o = quarter; scl_d = 1'b0;
      end
      S_BIT_H1: if (expire_i) begin
        state_d = S_BIT_H2; load_o = 1'b1; len_o = half - quarter;
        if (is_rd_q) rbit_d = sda_i;
      end
      S_BIT_H2: if (expire_i) begin
        state_d = S_IDLE; scl_d = 1'b1; done_d = 1'b1;
      end
      S_STO_L1: if (expire_i) begin
        state_d = S_STO_L2; load_o = 1'b1; len_o = half - r.sda_dly; sda_d = 1'b1;
      end
      S_STO_L2: if (expire_i) begin
        state_d = S_STO_HD; load_o = 1'b1; len_o = r.sto_hold; scl_d = 1'b0;
      end
      S_STO_HD: if (expire_i) begin
        state_d = S_IDLE; sda_d = 1'b0; done_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rate_q  <= '0;
      is_rd_q <= 1'b0;
      wbit_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      rbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) rate_q <= rate_i;
      is_rd_q <= is_rd_d;
      wbit_q  <= wbit_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      rbit_q  <= rbit_d;
    end
  end

  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
  assign done_o   = done_q;
  assign rd_bit_o = rbit_q;
endmodule

// File: rtl/i2c_bt_gen.sv
module i2c_bt_gen
  import i2c_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rate_idx_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             wr_bit_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             rd_bit_o
);
  rate_t            rate;
  logic             load, expire;
  logic [CNT_W-1:0] len;

  i2c_bt_rate_lut u_lut (
    .idx_i  (rate_idx_i),
    .rate_o (rate)
  );

  i2c_bt_timer #(.W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .len_i    (len),
    .expire_o (expire)
  );

  i2c_bt_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wr_bit_i (wr_bit_i),
    .sda_i    (sda_i),
    .rate_i   (rate),
    .expire_i (expire),
    .load_o   (load),
    .len_o    (len),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .done_o   (done_o),
    .rd_bit_o (rd_bit_o)
  );
endmodule

// File: rtl/i2c_bt_checker.sv
module i2c_bt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic done_o,
  input logic rd_bit_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!scl_oe_o && !sda_oe_o && !done_o && !rd_bit_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_single_line_move_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_oe_o) |-> $stable(sda_oe_o));

  // Completion coincides with the final line edge of every command.
  assert_done_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!$stable(scl_oe_o) || !$stable(sda_oe_o)));

  assert_scl_high_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |=> !scl_oe_o);
endmodule

bind i2c_bt_gen i2c_bt_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .done_o   (done_o),
  .rd_bit_o (rd_bit_o)
);

// File: tb/i2c_bt_gen_test.sv
module i2c_bt_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] idx = 6'h14;
  logic       sta = 1'b0, sto = 1'b0, wr = 1'b0, rd = 1'b0, wbit = 1'b0;
  logic       slave_sda = 1'b1;
  logic       sda_line;
  logic       scl_oe, sda_oe, done, rbit;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_oe ? 1'b0 : slave_sda;

  i2c_bt_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .rate_idx_i(idx),
    .start_i(sta), .stop_i(sto), .wr_i(wr), .rd_i(rd), .wr_bit_i(wbit),
    .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .done_o(done), .rd_bit_o(rbit)
  );

  // cmd: 0 START, 1 STOP, 2 write, 3 read
  typedef struct packed {
    logic [1:0]  cmd;
    logic [5:0]  idx;
    logic        wb;
    logic        slv;
    logic [11:0] per, dly, sth, sph;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 6'h14, 1'b0, 1'b1, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd2, 6'h14, 1'b1, 1'b1, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd2, 6'h14, 1'b0, 1'b1, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd3, 6'h14, 1'b0, 1'b1, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd1, 6'h14, 1'b0, 1'b1, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd0, 6'h18, 1'b0, 1'b0, 12'd80, 12'd9, 12'd38, 12'd41},
    '{2'd2, 6'h18, 1'b1, 1'b0, 12'd80, 12'd9, 12'd38, 12'd41},
    '{2'd2, 6'h18, 1'b0, 1'b0, 12'd80, 12'd9, 12'd38, 12'd41},
    '{2'd3, 6'h18, 1'b0, 1'b0, 12'd80, 12'd9, 12'd38, 12'd41},
    '{2'd1, 6'h18, 1'b0, 1'b0, 12'd80, 12'd9, 12'd38, 12'd41},
    '{2'd0, 6'h1E, 1'b0, 1'b1, 12'd192, 12'd33, 12'd94, 12'd97},
    '{2'd2, 6'h1E, 1'b1, 1'b1, 12'd192, 12'd33, 12'd94, 12'd97},
    '{2'd2, 6'h1E, 1'b0, 1'b1, 12'd192, 12'd33, 12'd94, 12'd97},
    '{2'd3, 6'h1E, 1'b0, 1'b1, 12'd192, 12'd33, 12'd94, 12'd97},
    '{2'd1, 6'h1E, 1'b0, 1'b1, 12'd192, 12'd33, 12'd94, 12'd97},
    '{2'd0, 6'h36, 1'b0, 1'b0, 12'd1536, 12'd257, 12'd766, 12'd769},
    '{2'd2, 6'h36, 1'b1, 1'b0, 12'd1536, 12'd257, 12'd766, 12'd769},
    '{2'd2, 6'h36, 1'b0, 1'b0, 12'd1536, 12'd257, 12'd766, 12'd769},
    '{2'd3, 6'h36, 1'b0, 1'b0, 12'd1536, 12'd257, 12'd766, 12'd769},
    '{2'd1, 6'h36, 1'b0, 1'b0, 12'd1536, 12'd257, 12'd766, 12'd769},
    '{2'd0, 6'h3F, 1'b0, 1'b1, 12'd3840, 12'd513, 12'd1918, 12'd1921},
    '{2'd2, 6'h3F, 1'b1, 1'b1, 12'd3840, 12'd513, 12'd1918, 12'd1921},
    '{2'd2, 6'h3F, 1'b0, 1'b1, 12'd3840, 12'd513, 12'd1918, 12'd1921},
    '{2'd3, 6'h3F, 1'b0, 1'b1, 12'd3840, 12'd513, 12'd1918, 12'd1921},
    '{2'd1, 6'h3F, 1'b0, 1'b1, 12'd3840, 12'd513, 12'd1918, 12'd1921},
    '{2'd0, 6'h07, 1'b0, 1'b0, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd2, 6'h07, 1'b1, 1'b0, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd2, 6'h07, 1'b0, 1'b0, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd3, 6'h07, 1'b0, 1'b0, 12'd80, 12'd17, 12'd34, 12'd41},
    '{2'd1, 6'h07, 1'b0, 1'b0, 12'd80, 12'd17, 12'd34, 12'd41}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mask: [0] START [1] STOP [2] write [3] read. Times count cycles from the accepting edge.
  task automatic run(input logic [3:0] mask, input logic [5:0] ix, input logic wb,
                     input logic slv, input bit disturb,
                     output int ts1, output int ts2, output int trel,
                     output int tdrv, output int tdone);
    logic ps, pd;
    ts1 = -1; ts2 = -1; trel = -1; tdrv = -1; tdone = -1;
    @(negedge clk);
    idx = ix; wbit = wb; slave_sda = slv;
    {rd, wr, sto, sta} = mask;
    ps = scl_oe; pd = sda_oe;
    @(negedge clk);
    {rd, wr, sto, sta} = 4'b0;
    for (int t = 0; t < 20000; t++) begin
      if (disturb && t == 1) begin idx = 6'h3F; wbit = ~wb; sto = 1'b1; sta = 1'b1; end
      if (disturb && t == 2) begin sto = 1'b0; sta = 1'b0; end
      if (sda_oe != pd) begin if (ts1 < 0) ts1 = t; ts2 = t; end
      if (ps && !scl_oe && trel < 0) trel = t;
      if (!ps && scl_oe && tdrv < 0) tdrv = t;
      ps = scl_oe; pd = sda_oe;
      if (done) begin tdone = t; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string req, input int n);
    logic s0, d0;
    int moved;
    s0 = scl_oe; d0 = sda_oe; moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (scl_oe != s0 || sda_oe != d0 || done) moved++;
    end
    chk(req, moved, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s1, s2, tr, td, tn;
    int p, h;
    // R1: outputs while reset is held, then after release
    repeat (3) @(negedge clk);
    chk("R1 scl", scl_oe, 0); chk("R1 sda", sda_oe, 0);
    chk("R1 done", done, 0);  chk("R1 rbit", rbit, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 scl idle", scl_oe, 0); chk("R1 sda idle", sda_oe, 0);

    // R2 through the timing of each command at each rate
    for (int v = 0; v < NV; v++) begin
      p = VECS[v].per; h = p / 2;
      run(4'b1 << VECS[v].cmd, VECS[v].idx, VECS[v].wb, VECS[v].slv, 1'b0, s1, s2, tr, td, tn);
      case (VECS[v].cmd)
        2'd0: begin // R5 R2
          chk("R5/R2 start sda fall", s1, p);
          chk("R5 scl release", tr, -1);
          chk("R5/R2 start scl fall", td, p + VECS[v].sth);
          chk("R5 start done", tn, p + VECS[v].sth);
        end
        2'd1: begin // R6 R2
          chk("R6/R2 stop sda low", s1, VECS[v].dly);
          chk("R6 stop scl release", tr, h);
          chk("R6/R2 stop sda release", s2, h + VECS[v].sph);
          chk("R6 stop done", tn, h + VECS[v].sph);
        end
        default: begin // R3 R4 R2
          chk("R3/R4 sda change", s1, VECS[v].dly);
          chk("R3/R4 scl release", tr, h);
          chk("R3/R4 scl fall", td, p);
          chk("R3/R4 done", tn, p);
          if (VECS[v].cmd == 2'd3) chk("R4 read bit", rbit, VECS[v].slv);
        end
      endcase
    end

    // R7: index and bit changed in mid-command
    run(4'b0001, 6'h14, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    run(4'b0100, 6'h14, 1'b1, 1'b1, 1'b1, s1, s2, tr, td, tn);
    chk("R7 bit kept", s1, 17);
    chk("R7 sda level", sda_oe, 0);
    chk("R7 period kept", tn, 80);
    // R8: the START/STOP strobes fired during that write left no trace
    quiet("R8 busy strobes ignored", 300);

    // R8: STOP wins over write and read
    run(4'b1110, 6'h18, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    chk("R8 stop priority sda", s2, 40 + 41);
    chk("R8 stop priority done", tn, 81);
    // R8: START wins over STOP
    run(4'b0011, 6'h18, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    chk("R8 start priority", tn, 80 + 38);
    // R5: repeated START from SCL low with SDA low
    run(4'b0100, 6'h18, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    run(4'b0001, 6'h18, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    chk("R5 rep sda release", s1, 0);
    chk("R5 rep scl release", tr, 40);
    chk("R5 rep sda fall", s2, 80);
    chk("R5 rep scl fall", td, 118);
    // R4: read with the slave pulling low, then the bit holds across a write
    run(4'b1000, 6'h18, 1'b0, 1'b0, 1'b0, s1, s2, tr, td, tn);
    chk("R4 read zero", rbit, 0);
    run(4'b0100, 6'h18, 1'b1, 1'b1, 1'b0, s1, s2, tr, td, tn);
    chk("R4 bit held", rbit, 0);
    run(4'b0010, 6'h18, 1'b0, 1'b1, 1'b0, s1, s2, tr, td, tn);
    chk("R6 bus released scl", scl_oe, 0);
    chk("R6 bus released sda", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule